// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

This block gathers eight interrupt request lines, ranks them by fixed priority and raises one interrupt line toward the processor. The processor answers with an acknowledge handshake of two pulses. The first pulse moves the winning request into the in-service set. The second pulse returns an 8-bit vector: the programmed base with the line number in its low three bits.

Software reaches the block through a one-bit address port with an even and an odd location. A write to the even location with bit 4 set opens a configuration sequence, and the next odd writes complete it. Once configured, odd writes load the mask and even writes issue end-of-interrupt commands or pick which status register an even read returns.

Two or more copies can be cascaded. A master is told which of its inputs carry a slave. When such an input wins, the master puts the line number on `cas_out` and leaves the vector to the slave. A slave answers the second pulse only when `cas_in` matches its programmed identity.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: An even write with bit 4 set restarts configuration. It clears the mask, the in-service set and the latched edge requests, and `int_out` stays low until the sequence completes.
- R2: In the configuration word, bit 0 = 1 means a fourth word follows and bit 1 = 0 means a third (cascade) word follows. The odd writes fill word 2, then word 3 if expected, then word 4 if expected. After that, odd writes load the mask.
- R3: Configuration bit 3 = 0 selects edge mode, where a rising input latches a request that stays until acknowledged. Bit 3 = 1 selects level mode, where the request register follows the input.
- R4: Line 0 has the highest priority and line 7 the lowest. A line whose mask bit is 1 neither raises `int_out` nor wins an acknowledge.
- R5: The first acknowledge pulse sets the winner's in-service bit. On the cycle after the second pulse, `vec_valid` is high and `vec_out` = {word2[7:3], line}.
- R6: `int_out` rises only for an unmasked request whose priority is higher than every in-service line. With word 4 bit 4 set on a master, a request on a cascade input also passes when that same input is in service.
- R7: Even write 0x20 clears the highest-priority in-service bit. Even write 0x60|L clears in-service bit L.
- R8: With word 4 bit 1 set, the in-service bit is cleared at the second acknowledge pulse.
- R9: An even write with bits [4:3] = 01 and bit 1 = 1 picks the even read source: bit 0 = 0 gives the request register and bit 0 = 1 gives the in-service register. An odd read returns the mask.
- R10: On a master, when the winner's bit is set in word 3, `cas_out` carries the line number from the first pulse until the second, and no vector is produced.
- R11: On a slave (`slave_sel` = 1 with cascade configured), the second pulse takes effect only when `cas_in` equals word3[2:0]. It then sets the winner's in-service bit and returns the vector.
- R12: An acknowledge with no eligible request returns vector {word2[7:3], 7} and leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = even location, 1 = odd location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Request inputs |
| inta | input | 1 | Acknowledge pulse, one cycle per pulse |
| slave_sel | input | 1 | 1 = this copy acts as a slave |
| cas_in | input | 3 | Cascade line number seen by a slave |
| cas_out | output | 3 | Cascade line number driven by a master |
| int_out | output | 1 | Interrupt line to the processor |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | 8 | Acknowledge vector |

## Verification
Every cycle, the assertions check four things: `int_out` stays quiet while configuration is incomplete, in-service bits appear only after an acknowledge pulse, a non-specific end-of-interrupt never adds in-service bits, and a vector only follows an acknowledge. They also check that `cas_out` only changes to a nonzero code on an acknowledge taken as master. The bench scenarios cover what needs a sequence of events: priority order and masking, nesting against the in-service set, both end-of-interrupt forms, automatic clearing, the choice between edge and level mode, the optional configuration words, and the routing of the vector between master and slave.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_W2, ST_W3, ST_W4, ST_RUN
  } cfg_st_e;

  function automatic logic is_start(input logic a, input logic [7:0] d);
    return !a && d[4];
  endfunction

  function automatic logic is_cmd(input logic a, input logic [7:0] d);
    return !a && !d[4] && !d[3];
  endfunction

  function automatic logic is_sel(input logic a, input logic [7:0] d);
    return !a && !d[4] && d[3];
  endfunction
endpackage

// File: rtl/cirq_cfg.sv
module cirq_cfg
  import cirq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               cfg_done,
  output logic               start_pulse,
  output logic [DATA_W-1:0]  base,
  output logic [DATA_W-1:0]  word3,
  output logic               level_mode,
  output logic               single,
  output logic               auto_eoi,
  output logic               nest_casc,
  output logic [N_LINES-1:0] mask,
  output logic               rd_isr,
  output logic               eoi_any,
  output logic               eoi_one,
  output logic [IDX_W-1:0]   eoi_lvl
);
  cfg_st_e st;
  logic    want4;

  assign cfg_done    = (st == ST_RUN);
  assign start_pulse = wr_en && is_start(addr, wdata[7:0]);
  assign eoi_any = wr_en && cfg_done && is_cmd(addr, wdata[7:0]) && (wdata[7:5] == 3'b001);
  assign eoi_one = wr_en && cfg_done && is_cmd(addr, wdata[7:0]) && (wdata[7:5] == 3'b011);
  assign eoi_lvl = wdata[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      want4      <= 1'b0;
      base       <= '0;
      word3      <= '0;
      level_mode <= 1'b0;
      single     <= 1'b0;
      auto_eoi   <= 1'b0;
      nest_casc  <= 1'b0;
      mask       <= '0;
      rd_isr     <= 1'b0;
    end else if (wr_en) begin
      if (start_pulse) begin
        st         <= ST_W2;
        level_mode <= wdata[3];
        single     <= wdata[1];
        want4      <= wdata[0];
        mask       <= '0;
        auto_eoi   <= 1'b0;
        nest_casc  <= 1'b0;
        rd_isr     <= 1'b0;
        word3      <= '0;
      end else if (addr) begin
        unique case (st)
          ST_W2: begin
            base <= wdata;
            if (!single)    st <= ST_W3;
            else if (want4) st <= ST_W4;
            else            st <= ST_RUN;
          end
          ST_W3: begin
            word3 <= wdata;
            st    <= want4 ? ST_W4 : ST_RUN;
          end
          ST_W4: begin
            auto_eoi  <= wdata[1];
            nest_casc <= wdata[4];
            st        <= ST_RUN;
          end
          ST_RUN:  mask <= wdata[N_LINES-1:0];
          default: ;
        endcase
      end else if (is_sel(addr, wdata[7:0]) && cfg_done && wdata[1]) begin
        rd_isr <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/cirq_resolve.sv
module cirq_resolve #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] irr,
  input  logic [N_LINES-1:0] isr,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] casc,
  input  logic               nest_casc,
  output logic               found,
  output logic [IDX_W-1:0]   win,
  output logic [N_LINES-1:0] isr_top
);
  logic [N_LINES:0]   above;
  logic [N_LINES-1:0] elig;

  assign above[0] = 1'b0;
  for (genvar i = 0; i < N_LINES; i++) begin : g_lvl
    assign above[i+1]  = above[i] | isr[i];
    assign elig[i]     = irr[i] & ~mask[i] & ~above[i] & (~isr[i] | (nest_casc & casc[i]));
    assign isr_top[i]  = isr[i] & ~above[i];
  end

  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               inta,
  input  logic               slave_sel,
  input  logic [IDX_W-1:0]   cas_in,
  output logic [IDX_W-1:0]   cas_out,
  output logic               int_out,
  output logic               vec_valid,
  output logic [DATA_W-1:0]  vec_out
);
  logic               cfg_done, start_pulse, level_mode, single, auto_eoi, nest_casc;
  logic               rd_isr, eoi_any, eoi_one;
  logic [IDX_W-1:0]   eoi_lvl;
  logic [DATA_W-1:0]  base, word3;
  logic [N_LINES-1:0] mask;

  logic [N_LINES-1:0] irq_prev, irr_q, isr_q, casc, isr_top, taken, isr_set, isr_clr;
  logic               found, ack_phase, win_ok_q, win_cas_q;
  logic [IDX_W-1:0]   win, win_q;
  logic               act_master, slave_hit, ack1, ack2, take1, take2;

  function automatic logic [N_LINES-1:0] to_oh(input logic [IDX_W-1:0] k);
    logic [N_LINES-1:0] r;
    r    = '0;
    r[k] = 1'b1;
    return r;
  endfunction

  cirq_cfg #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cfg_done(cfg_done), .start_pulse(start_pulse), .base(base), .word3(word3),
    .level_mode(level_mode), .single(single), .auto_eoi(auto_eoi),
    .nest_casc(nest_casc), .mask(mask), .rd_isr(rd_isr),
    .eoi_any(eoi_any), .eoi_one(eoi_one), .eoi_lvl(eoi_lvl)
  );

  assign act_master = !slave_sel || single;
  assign casc       = act_master && !single ? word3[N_LINES-1:0] : '0;
  assign slave_hit  = !act_master && (cas_in == word3[IDX_W-1:0]);

  cirq_resolve #(.N_LINES(N_LINES)) u_res (
    .irr(irr_q), .isr(isr_q), .mask(mask), .casc(casc), .nest_casc(nest_casc),
    .found(found), .win(win), .isr_top(isr_top)
  );

  assign ack1  = inta && !ack_phase && cfg_done;
  assign ack2  = inta && ack_phase;
  assign take1 = ack1 && act_master && found;
  assign take2 = ack2 && slave_hit && found;
  assign taken = (take1 || take2) ? to_oh(win) : '0;

  always_comb begin
    isr_set = '0;
    if (take1 || (take2 && !auto_eoi)) isr_set = to_oh(win);
    isr_clr = '0;
    if (eoi_any) isr_clr = isr_clr | isr_top;
    if (eoi_one) isr_clr = isr_clr | to_oh(eoi_lvl);
    if (ack2 && act_master && auto_eoi && win_ok_q) isr_clr = isr_clr | to_oh(win_q);
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst || start_pulse) begin
        irr_q[i] <= 1'b0;
      end else if (level_mode) begin
        irr_q[i] <= irq_in[i];
      end else begin
        irr_q[i] <= (irq_in[i] & ~irq_prev[i]) | (irr_q[i] & ~taken[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev  <= '0;
      isr_q     <= '0;
      ack_phase <= 1'b0;
      win_q     <= '0;
      win_ok_q  <= 1'b0;
      win_cas_q <= 1'b0;
      cas_out   <= '0;
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      rdata     <= '0;
    end else begin
      irq_prev  <= irq_in;
      isr_q     <= start_pulse ? '0 : ((isr_q & ~isr_clr) | isr_set);
      int_out   <= found && cfg_done && !start_pulse;
      vec_valid <= 1'b0;
      if (start_pulse) begin
        ack_phase <= 1'b0;
        cas_out   <= '0;
      end else if (ack1) begin
        ack_phase <= 1'b1;
        win_q     <= win;
        win_ok_q  <= found;
        win_cas_q <= found && casc[win];
        if (act_master && found && casc[win]) cas_out <= win;
      end else if (ack2) begin
        ack_phase <= 1'b0;
        cas_out   <= '0;
        if (act_master && !win_cas_q) begin
          vec_valid <= 1'b1;
          vec_out   <= {base[DATA_W-1:IDX_W], win_ok_q ? win_q : {IDX_W{1'b1}}};
        end else if (slave_hit) begin
          vec_valid <= 1'b1;
          vec_out   <= {base[DATA_W-1:IDX_W], found ? win : {IDX_W{1'b1}}};
        end
      end
      if (rd_en) begin
        rdata <= '0;
        if (addr)        rdata[N_LINES-1:0] <= mask;
        else if (rd_isr) rdata[N_LINES-1:0] <= isr_q;
        else             rdata[N_LINES-1:0] <= irr_q;
      end
    end
  end
endmodule

// File: rtl/cirq_checker.sv
module cirq_checker #(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst,
  input logic               inta,
  input logic               wr_en,
  input logic               addr,
  input logic [DATA_W-1:0]  wdata,
  input logic               slave_sel,
  input logic               int_out,
  input logic               vec_valid,
  input logic [IDX_W-1:0]   cas_out,
  input logic [N_LINES-1:0] isr,
  input logic               cfg_done
);
  a_r1_quiet_until_done: assert property (@(posedge clk) disable iff (rst)
    (!cfg_done && !$past(cfg_done)) |-> !int_out);

  a_r5_isr_grows_on_ack: assert property (@(posedge clk) disable iff (rst)
    ($countones(isr) > $countones($past(isr))) |-> $past(inta));

  a_r5_vector_follows_ack: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta));

  a_r7_eoi_never_adds: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata == 8'h20 && !inta) |=> ($countones(isr) <= $countones($past(isr))));

  a_r10_cas_from_master_ack: assert property (@(posedge clk) disable iff (rst)
    (cas_out != '0 && !$stable(cas_out)) |-> ($past(inta) && !$past(slave_sel)));
endmodule

bind cascade_irq_ctrl cirq_checker #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .inta(inta), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .slave_sel(slave_sel), .int_out(int_out), .vec_valid(vec_valid),
  .cas_out(cas_out), .isr(isr_q), .cfg_done(cfg_done)
);

// File: tb/cascade_irq_ctrl_test.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, rd_en = 0, addr = 0, inta = 0, slave_sel = 0;
  logic [7:0] wdata = 0, irq_in = 0;
  logic [2:0] cas_in = 0;
  logic [7:0] rdata, vec_out;
  logic [2:0] cas_out;
  logic       int_out, vec_valid;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  cascade_irq_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .inta(inta), .slave_sel(slave_sel),
    .cas_in(cas_in), .cas_out(cas_out), .int_out(int_out),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // ---------------- behavioural reference model ----------------
  int   ms;                        // 0 idle,1 word2,2 word3,3 word4,4 run
  logic m_lvl, m_sgl, m_w4, m_aeoi, m_sf, m_rsel, m_ph, m_wok, m_wcas;
  logic [7:0] m_base, m_w3, m_imr, m_irr, m_isr, m_prev, m_rd, m_vec;
  int   m_w;
  logic m_int, m_vv;
  logic [2:0] m_cas;

  function automatic int pick(input logic [7:0] irr, input logic [7:0] isr,
                              input logic [7:0] imr, input logic [7:0] cm, input logic sf);
    for (int i = 0; i < 8; i++) begin
      if (isr[i] && !(sf && cm[i])) return -1;
      if (irr[i] && !imr[i]) return i;
      if (isr[i]) return -1;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    int p; logic mst, hit, start, a1, a2;
    logic [7:0] cm, nirr, nisr;
    if (rst) begin
      ms = 0; m_lvl = 0; m_sgl = 0; m_w4 = 0; m_aeoi = 0; m_sf = 0; m_rsel = 0;
      m_ph = 0; m_wok = 0; m_wcas = 0; m_base = 0; m_w3 = 0; m_imr = 0; m_irr = 0;
      m_isr = 0; m_prev = 0; m_rd = 0; m_vec = 0; m_w = 0; m_int = 0; m_vv = 0; m_cas = 0;
    end else begin
      mst   = !slave_sel || m_sgl;
      cm    = (mst && !m_sgl) ? m_w3 : 8'h00;
      hit   = !mst && (cas_in == m_w3[2:0]);
      p     = pick(m_irr, m_isr, m_imr, cm, m_sf);
      start = wr_en && !addr && wdata[4];
      a1    = inta && !m_ph && ms == 4;
      a2    = inta && m_ph;
      if (rd_en) m_rd = addr ? m_imr : (m_rsel ? m_isr : m_irr);
      m_int = (p >= 0) && ms == 4 && !start;
      m_vv  = 0;
      nisr  = m_isr;
      nirr  = m_lvl ? irq_in : (m_irr | (irq_in & ~m_prev));
      if (a1) begin
        m_ph = 1; m_wok = (p >= 0); m_w = p; m_wcas = (p >= 0) && cm[p];
        if (mst && p >= 0) begin
          nisr[p] = 1; if (!m_lvl) nirr[p] = 0;
          if (cm[p]) m_cas = 3'(p);
        end
      end else if (a2) begin
        m_ph = 0; m_cas = 0;
        if (mst && !m_wcas) begin
          m_vv = 1; m_vec = {m_base[7:3], m_wok ? 3'(m_w) : 3'd7};
          if (m_aeoi && m_wok) nisr[m_w] = 0;
        end else if (hit) begin
          m_vv = 1; m_vec = {m_base[7:3], p >= 0 ? 3'(p) : 3'd7};
          if (p >= 0) begin
            if (!m_aeoi) nisr[p] = 1;
            if (!m_lvl) nirr[p] = 0;
          end
        end
      end
      if (wr_en && ms == 4 && !addr && !wdata[4] && !wdata[3]) begin
        if (wdata[7:5] == 3'b001) begin
          for (int i = 0; i < 8; i++) if (m_isr[i]) begin nisr[i] = 0; break; end
        end
        if (wdata[7:5] == 3'b011) nisr[wdata[2:0]] = 0;
      end
      m_prev = irq_in;
      if (wr_en) begin
        if (start) begin
          ms = 1; m_lvl = wdata[3]; m_sgl = wdata[1]; m_w4 = wdata[0];
          m_imr = 0; m_aeoi = 0; m_sf = 0; m_rsel = 0; m_w3 = 0;
          nisr = 0; nirr = 0; m_ph = 0; m_cas = 0; m_vv = 0;
        end else if (addr) begin
          case (ms)
            1: begin m_base = wdata; ms = !m_sgl ? 2 : (m_w4 ? 3 : 4); end
            2: begin m_w3 = wdata; ms = m_w4 ? 3 : 4; end
            3: begin m_aeoi = wdata[1]; m_sf = wdata[4]; ms = 4; end
            4: m_imr = wdata;
            default: ;
          endcase
        end else if (wdata[3] && ms == 4 && wdata[1]) m_rsel = wdata[0];
      end
      m_isr = nisr; m_irr = nirr;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (int_out !== m_int || vec_valid !== m_vv || cas_out !== m_cas || rdata !== m_rd ||
          (m_vv && vec_out !== m_vec)) begin
        errors++;
        $display("FAIL R6/R5/R10/R9 cycle %0d: int=%b vv=%b vec=%h cas=%0d rd=%h expected int=%b vv=%b vec=%h cas=%0d rd=%h",
                 cycles, int_out, vec_valid, vec_out, cas_out, rdata, m_int, m_vv, m_vec, m_cas, m_rd);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic ack(output logic vv, output logic [7:0] vec, output logic [2:0] cas);
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0; cas = cas_out;
    @(negedge clk); inta = 1;
    @(negedge clk); inta = 0; vv = vec_valid; vec = vec_out;
  endtask

  initial begin
    logic vv; logic [7:0] v, d; logic [2:0] c;
    tick(3); rst = 0; tick(1);
    check("R1 reset int", {7'd0, int_out}, 8'h00);
    check("R1 reset vec_valid", {7'd0, vec_valid}, 8'h00);

    // single master, edge, word4 present
    wr(0, 8'h13); wr(1, 8'h40);
    irq_in = 8'h08; tick(3);
    check("R1 quiet before word4", {7'd0, int_out}, 8'h00);
    wr(1, 8'h00); tick(2);
    check("R2 int after word4", {7'd0, int_out}, 8'h01);
    check("R3 edge latch", {7'd0, int_out}, 8'h01);
    irq_in = 8'h0A; tick(2);
    ack(vv, v, c);
    check("R4 priority line1", v, 8'h41);
    check("R5 vector valid", {7'd0, vv}, 8'h01);
    wr(0, 8'h0B); rd(0, d);
    check("R9 isr read", d, 8'h02);
    tick(1);
    check("R6 lower blocked by isr", {7'd0, int_out}, 8'h00);
    wr(0, 8'h0A); rd(0, d);
    check("R9 irr read", d, 8'h08);
    wr(0, 8'h20); tick(2);
    check("R7 nonspecific eoi", {7'd0, int_out}, 8'h01);
    ack(vv, v, c);
    check("R5 vector line3", v, 8'h43);
    wr(0, 8'h63); wr(0, 8'h0B); rd(0, d);
    check("R7 specific eoi", d, 8'h00);
    irq_in = 8'h00; tick(1);
    wr(1, 8'h04); irq_in = 8'h04; tick(3);
    check("R4 masked no int", {7'd0, int_out}, 8'h00);
    rd(1, d);
    check("R9 mask read", d, 8'h04);
    ack(vv, v, c);
    check("R12 spurious vector", v, 8'h47);
    rd(0, d);
    check("R12 isr unchanged", d, 8'h00);

    // restart mid-operation: clears mask
    irq_in = 8'h00;
    wr(0, 8'h1A); wr(1, 8'h80);
    wr(1, 8'hFE); rd(1, d);
    check("R2 no word4 so mask", d, 8'hFE);
    check("R1 restart cleared mask before reload", {7'd0, int_out}, 8'h00);
    irq_in = 8'h01; tick(3);
    check("R3 level int", {7'd0, int_out}, 8'h01);
    ack(vv, v, c);
    check("R3 level vector", v, 8'h80);
    irq_in = 8'h00; wr(0, 8'h0A); rd(0, d);
    check("R3 level irr follows", d, 8'h00);
    wr(0, 8'h20);

    // cascade master with auto eoi
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h02);
    irq_in = 8'h20; tick(3);
    ack(vv, v, c);
    check("R8 aeoi vector", v, 8'h25);
    wr(0, 8'h0B); rd(0, d);
    check("R8 isr cleared", d, 8'h00);
    irq_in = 8'h24; tick(3);
    ack(vv, v, c);
    check("R10 cas code", {5'd0, c}, 8'h02);
    check("R10 no vector", {7'd0, vv}, 8'h00);

    // special nesting on cascade input
    irq_in = 8'h00;
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h10);
    irq_in = 8'h04; tick(3);
    ack(vv, v, c);
    irq_in = 8'h00; tick(2); irq_in = 8'h04; tick(3);
    check("R6 nested cascade input", {7'd0, int_out}, 8'h01);

    // slave
    irq_in = 8'h00; slave_sel = 1;
    wr(0, 8'h11); wr(1, 8'h70); wr(1, 8'h03); wr(1, 8'h00);
    irq_in = 8'h10; tick(3);
    cas_in = 3'd5; ack(vv, v, c);
    check("R11 other id silent", {7'd0, vv}, 8'h00);
    wr(0, 8'h0B); rd(0, d);
    check("R11 isr untouched", d, 8'h00);
    cas_in = 3'd3; ack(vv, v, c);
    check("R11 slave vector", v, 8'h74);
    rd(0, d);
    check("R11 slave isr", d, 8'h10);
    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule